// File: doc/BRIEF.md
# Interrupt and Wait Sequencer

This block sits beside an instruction-execution core and, each time the core reports an instruction boundary, decides whether the core should take an interrupt, continue with the next instruction, or hold still. It tracks a maskable request line, a non-maskable request line and an interrupt-enable flag. Software sets and clears the flag through two strobes. The block also handles the coprocessor-synchronising wait instruction, which may have to idle until an external busy line goes low.

A maskable request is a level. It is honoured only while the enable flag is set, and it leads to a timed acknowledge handshake: two acknowledge pulses with a gap between them, then a one-cycle vector-valid strobe. A non-maskable request is a rising edge. It is latched until it is serviced, bypasses the flag, takes priority over a maskable request, and needs no handshake. Taking either kind of interrupt clears the enable flag. An interrupt that arrives while the wait instruction is idling ends the idle and is taken at once.

Top module: `intw_seq`

## Requirements
- R1: After reset, take_o, take_nmi_o, ack_pulse_o, vec_valid_o, stall_o and ien_o are all 0.
- R2: ien_o goes to 1 on the cycle after an ien_set_i strobe and to 0 on the cycle after an ien_clr_i strobe. When an interrupt is taken in the same cycle as ien_set_i, ien_o reads 0 on the following cycle.
- R3: When bnd_i is sampled high while mask_req_i is high, ien_o is 1 and no non-maskable request is pending, take_o is 1 with take_nmi_o = 0 on the next cycle, and ien_o is 0 from that cycle on.
- R4: While ien_o is 0, mask_req_i has no effect (no take, no acknowledge). A maskable request that falls before the boundary is not remembered.
- R5: A rising edge on nmask_req_i is latched. At the next accepted boundary, take_o is 1 with take_nmi_o = 1 on the following cycle, whatever the value of ien_o. Neither ack_pulse_o nor vec_valid_o follows.
- R6: When both kinds are pending at a boundary, the non-maskable one is taken (take_nmi_o = 1). The maskable request is then blocked until the flag is set again.
- R7: After a maskable take, ack_pulse_o is high for ACK_CYC cycles starting with the take cycle, low for GAP_CYC cycles, high again for ACK_CYC cycles. vec_valid_o is then high for exactly one cycle.
- R8: A boundary strobe that arrives while the acknowledge sequence runs is ignored (take_o stays 0).
- R9: A boundary with wait_op_i = 1 and sync_busy_i = 0 and no interrupt to take does not raise stall_o.
- R10: A boundary with wait_op_i = 1 and sync_busy_i = 1 and no interrupt to take raises stall_o on the next cycle. stall_o stays high until the cycle after sync_busy_i is sampled 0.
- R11: While stall_o is high, a pending non-maskable request or an enabled maskable request is taken without waiting for a boundary. stall_o falls in the same cycle that take_o rises.
- R12: A non-maskable line held high produces a single take. A further take needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_req_i | input | 1 | Maskable request, level sensitive |
| nmask_req_i | input | 1 | Non-maskable request, rising-edge sensitive |
| ien_set_i | input | 1 | Strobe: set the interrupt-enable flag |
| ien_clr_i | input | 1 | Strobe: clear the interrupt-enable flag (wins over set) |
| bnd_i | input | 1 | Current instruction has completed |
| wait_op_i | input | 1 | The completing instruction is the wait instruction |
| sync_busy_i | input | 1 | External busy line tested by the wait instruction |
| take_o | output | 1 | One-cycle pulse: an interrupt is being taken |
| take_nmi_o | output | 1 | Kind of the take: 1 non-maskable, 0 maskable |
| ack_pulse_o | output | 1 | Acknowledge pulse output for maskable takes |
| vec_valid_o | output | 1 | One-cycle strobe after the second acknowledge pulse |
| stall_o | output | 1 | Core must hold while high |
| ien_o | output | 1 | Current interrupt-enable flag |

## Verification
The checker watches properties that hold on every cycle: a maskable take coincides with an acknowledge pulse and needs the flag to have been set the cycle before, a non-maskable take never carries one, every take leaves the flag clear, the vector strobe follows an acknowledge pulse, and the stall drops once the busy line is seen low. The bench shows what needs a scenario: the exact pulse and gap widths of the acknowledge sequence, priority when both requests are pending, that a boundary during the sequence or a dropped maskable request is lost, single-shot edge behaviour on a held non-maskable line, and an interrupt cutting a wait short. A seeded random run compares take decisions and the flag against a transaction-level model.

// File: rtl/intw_pkg.sv
package intw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ACK1 = 3'd1,
        PH_GAP  = 3'd2,
        PH_ACK2 = 3'd3,
        PH_VEC  = 3'd4
    } ack_ph_e;

    typedef enum logic {
        MD_RUN  = 1'b0,
        MD_WAIT = 1'b1
    } mode_e;

    typedef struct packed {
        logic prev;
        logic pend;
    } edge_st_s;

    typedef struct packed {
        mode_e mode;
        logic  take;
        logic  kind;
    } dec_st_s;

endpackage

// File: rtl/intw_nmi_latch.sv
module intw_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clear_i,
    output logic pend_o
);
    import intw_pkg::*;

    edge_st_s st_d, st_q;
    logic     rise;

    always_comb begin
        st_d      = st_q;
        rise      = req_i & ~st_q.prev;
        st_d.prev = req_i;
        // a fresh edge in the clearing cycle stays pending
        st_d.pend = (st_q.pend & ~clear_i) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/intw_ien_flag.sv
module intw_ien_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic take_i,
    output logic ien_o
);
    logic ien_d, ien_q;

    always_comb begin
        ien_d = ien_q;
        if (take_i || clr_i) begin
            ien_d = 1'b0;
        end else if (set_i) begin
            ien_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else begin
            ien_q <= ien_d;
        end
    end

    assign ien_o = ien_q;

endmodule

// File: rtl/intw_ack_seq.sv
module intw_ack_seq #(
    parameter int ACK_CYC = 2,
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic ack_o,
    output logic vec_o
);
    import intw_pkg::*;

    localparam int LONGEST = (ACK_CYC > GAP_CYC) ? ACK_CYC : GAP_CYC;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] ACK_LAST = CW'(ACK_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        ack_ph_e         ph;
        logic [CW-1:0]   cnt;
    } seq_st_s;

    seq_st_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_ACK1;
                    st_d.cnt = '0;
                end
            end
            PH_ACK1: begin
                if (st_q.cnt == ACK_LAST) begin
                    st_d.ph  = PH_GAP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (st_q.cnt == GAP_LAST) begin
                    st_d.ph  = PH_ACK2;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_ACK2: begin
                if (st_q.cnt == ACK_LAST) begin
                    st_d.ph  = PH_VEC;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_VEC: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.ph != PH_IDLE);
    assign ack_o  = (st_q.ph == PH_ACK1) || (st_q.ph == PH_ACK2);
    assign vec_o  = (st_q.ph == PH_VEC);

endmodule

// File: rtl/intw_seq.sv
module intw_seq #(
    parameter int ACK_CYC = 2,
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_req_i,
    input  logic nmask_req_i,
    input  logic ien_set_i,
    input  logic ien_clr_i,
    input  logic bnd_i,
    input  logic wait_op_i,
    input  logic sync_busy_i,
    output logic take_o,
    output logic take_nmi_o,
    output logic ack_pulse_o,
    output logic vec_valid_o,
    output logic stall_o,
    output logic ien_o
);
    import intw_pkg::*;

    dec_st_s st_d, st_q;

    logic nm_pend;
    logic seq_busy;
    logic ien_now;
    logic decide;
    logic take_nm;
    logic take_m;
    logic go_wait;

    intw_nmi_latch u_nm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (nmask_req_i),
        .clear_i (take_nm),
        .pend_o  (nm_pend)
    );

    intw_ien_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ien_set_i),
        .clr_i  (ien_clr_i),
        .take_i (take_nm | take_m),
        .ien_o  (ien_now)
    );

    intw_ack_seq #(
        .ACK_CYC (ACK_CYC),
        .GAP_CYC (GAP_CYC)
    ) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (take_m),
        .busy_o  (seq_busy),
        .ack_o   (ack_pulse_o),
        .vec_o   (vec_valid_o)
    );

    always_comb begin
        st_d = st_q;
        // a decision point: an accepted boundary, or every cycle of a wait idle
        decide  = ((st_q.mode == MD_RUN) && bnd_i && !seq_busy)
               || (st_q.mode == MD_WAIT);
        take_nm = decide && nm_pend;
        take_m  = decide && !nm_pend && mask_req_i && ien_now;
        go_wait = decide && (st_q.mode == MD_RUN) && !take_nm && !take_m
               && wait_op_i && sync_busy_i;

        st_d.take = take_nm | take_m;
        st_d.kind = take_nm;
        if (go_wait) begin
            st_d.mode = MD_WAIT;
        end else if (st_q.mode == MD_WAIT && (take_nm || take_m || !sync_busy_i)) begin
            st_d.mode = MD_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_RUN, take: 1'b0, kind: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o     = st_q.take;
    assign take_nmi_o = st_q.take & st_q.kind;
    assign stall_o    = (st_q.mode == MD_WAIT);
    assign ien_o      = ien_now;

endmodule

// File: rtl/intw_seq_chk.sv
module intw_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mask_req_i,
    input logic sync_busy_i,
    input logic take_o,
    input logic take_nmi_o,
    input logic ack_pulse_o,
    input logic vec_valid_o,
    input logic stall_o,
    input logic ien_o
);
    // R3: a maskable take starts the acknowledge pulse in the same cycle
    p_mask_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o) |-> ack_pulse_o);

    // R4: a maskable take needs the flag and the request one cycle earlier
    p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o) |-> ($past(ien_o) && $past(mask_req_i)));

    // R5: a non-maskable take carries no acknowledge
    p_nm_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_nmi_o) |-> (!ack_pulse_o && !vec_valid_o));

    // R2: any take leaves the enable flag clear
    p_take_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ien_o);

    // R7: the vector strobe follows an acknowledge pulse and never overlaps it
    p_vec_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ($past(ack_pulse_o) && !ack_pulse_o));

    p_ack_vec_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_pulse_o, vec_valid_o}));

    // R10: once the busy line is seen low the stall ends
    p_stall_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !sync_busy_i) |=> !stall_o);

    // R11: a take and a stall never coexist
    p_take_ends_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !stall_o);

endmodule

bind intw_seq intw_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_req_i  (mask_req_i),
    .sync_busy_i (sync_busy_i),
    .take_o      (take_o),
    .take_nmi_o  (take_nmi_o),
    .ack_pulse_o (ack_pulse_o),
    .vec_valid_o (vec_valid_o),
    .stall_o     (stall_o),
    .ien_o       (ien_o)
);

// File: tb/sim_intw_seq.sv
`timescale 1ns/1ps
module sim_intw_seq;

    localparam int ACK = 3;
    localparam int GAP = 2;
    localparam int SEQ_LEN = 2 * ACK + GAP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_req_i = 1'b0, nmask_req_i = 1'b0;
    logic ien_set_i = 1'b0, ien_clr_i = 1'b0;
    logic bnd_i = 1'b0, wait_op_i = 1'b0, sync_busy_i = 1'b0;
    logic take_o, take_nmi_o, ack_pulse_o, vec_valid_o, stall_o, ien_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    intw_seq #(.ACK_CYC(ACK), .GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .mask_req_i(mask_req_i), .nmask_req_i(nmask_req_i),
        .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
        .bnd_i(bnd_i), .wait_op_i(wait_op_i), .sync_busy_i(sync_busy_i),
        .take_o(take_o), .take_nmi_o(take_nmi_o), .ack_pulse_o(ack_pulse_o),
        .vec_valid_o(vec_valid_o), .stall_o(stall_o), .ien_o(ien_o)
    );

    // expected acknowledge level k cycles after a maskable boundary (k = 1 is the take cycle)
    function automatic logic exp_ack(int k);
        return (k >= 1 && k <= ACK) || (k > ACK + GAP && k <= 2 * ACK + GAP);
    endfunction

    function automatic logic exp_vec(int k);
        return (k == 2 * ACK + GAP + 1);
    endfunction

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_flag();
        ien_set_i = 1'b1; tick(); ien_set_i = 1'b0;
    endtask

    task automatic clr_flag();
        ien_clr_i = 1'b1; tick(); ien_clr_i = 1'b0;
    endtask

    task automatic boundary();
        bnd_i = 1'b1; tick(); bnd_i = 1'b0;
    endtask

    task automatic nm_pulse();
        nmask_req_i = 1'b1; tick(); nmask_req_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic m_ien, m_pend, r_req, e_take;
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 take", take_o, 0);
        chk("R1 kind", take_nmi_o, 0);
        chk("R1 ack", ack_pulse_o, 0);
        chk("R1 vec", vec_valid_o, 0);
        chk("R1 stall", stall_o, 0);
        chk("R1 ien", ien_o, 0);

        // R4 flag clear: maskable ignored
        mask_req_i = 1'b1;
        boundary();
        chk("R4 masked take", take_o, 0);
        chk("R4 masked ack", ack_pulse_o, 0);
        tick(2);
        chk("R4 masked ack later", ack_pulse_o, 0);
        mask_req_i = 1'b0;

        // R2 set and clear
        set_flag();
        chk("R2 set", ien_o, 1);
        clr_flag();
        chk("R2 clear", ien_o, 0);
        ien_set_i = 1'b1; ien_clr_i = 1'b1; tick();
        ien_set_i = 1'b0; ien_clr_i = 1'b0;
        chk("R2 clear wins", ien_o, 0);
        set_flag();

        // R3 and R7 maskable take and acknowledge shape
        mask_req_i = 1'b1;
        boundary();
        mask_req_i = 1'b0;
        chk("R3 take", take_o, 1);
        chk("R3 kind", take_nmi_o, 0);
        chk("R3 flag cleared", ien_o, 0);
        for (int k = 1; k <= SEQ_LEN + 1; k++) begin
            chk($sformatf("R7 ack k=%0d", k), ack_pulse_o, exp_ack(k));
            chk($sformatf("R7 vec k=%0d", k), vec_valid_o, exp_vec(k));
            if (k > 1) chk("R7 single take", take_o, 0);
            tick();
        end

        // R8 boundary during acknowledge is ignored; R2 take wins over set
        set_flag();
        mask_req_i = 1'b1;
        ien_set_i = 1'b1; bnd_i = 1'b1; tick();
        ien_set_i = 1'b0; bnd_i = 1'b0;
        chk("R2 take beats set", ien_o, 0);
        chk("R8 first take", take_o, 1);
        set_flag();
        boundary();
        chk("R8 ignored boundary", take_o, 0);
        tick(SEQ_LEN);
        boundary();
        chk("R8 after sequence", take_o, 1);
        mask_req_i = 1'b0;
        tick(SEQ_LEN + 1);

        // R4 request not latched
        set_flag();
        mask_req_i = 1'b1; tick(); mask_req_i = 1'b0;
        boundary();
        chk("R4 dropped request", take_o, 0);
        chk("R4 flag kept", ien_o, 1);
        clr_flag();

        // R5 non-maskable with flag clear
        nm_pulse();
        tick(3);
        chk("R5 no early take", take_o, 0);
        boundary();
        chk("R5 take", take_o, 1);
        chk("R5 kind", take_nmi_o, 1);
        for (int k = 0; k < 4; k++) begin
            chk("R5 no ack", ack_pulse_o, 0);
            chk("R5 no vec", vec_valid_o, 0);
            tick();
        end

        // R12 held line takes once
        nmask_req_i = 1'b1;
        tick(2);
        boundary();
        chk("R12 first", take_o, 1);
        tick();
        boundary();
        chk("R12 no retrigger", take_o, 0);
        nmask_req_i = 1'b0;
        tick();

        // R6 both pending: non-maskable first, maskable blocked after
        set_flag();
        mask_req_i = 1'b1;
        nm_pulse();
        boundary();
        chk("R6 nm first", take_o, 1);
        chk("R6 kind", take_nmi_o, 1);
        chk("R6 flag cleared", ien_o, 0);
        chk("R6 no ack", ack_pulse_o, 0);
        tick();
        boundary();
        chk("R6 maskable blocked", take_o, 0);
        set_flag();
        boundary();
        chk("R6 maskable after set", take_o, 1);
        chk("R6 maskable kind", take_nmi_o, 0);
        mask_req_i = 1'b0;
        tick(SEQ_LEN + 1);

        // R9 wait with busy low
        wait_op_i = 1'b1; sync_busy_i = 1'b0;
        boundary();
        wait_op_i = 1'b0;
        chk("R9 no stall", stall_o, 0);
        tick();
        chk("R9 no stall later", stall_o, 0);

        // R10 wait with busy high
        wait_op_i = 1'b1; sync_busy_i = 1'b1;
        boundary();
        wait_op_i = 1'b0;
        chk("R10 stall", stall_o, 1);
        tick(5);
        chk("R10 stall held", stall_o, 1);
        sync_busy_i = 1'b0;
        tick();
        chk("R10 released", stall_o, 0);

        // R11 non-maskable ends the stall
        wait_op_i = 1'b1; sync_busy_i = 1'b1;
        boundary();
        wait_op_i = 1'b0;
        tick(2);
        nm_pulse();
        chk("R11 latch cycle still stalled", stall_o, 1);
        chk("R11 latch cycle no take", take_o, 0);
        tick();
        chk("R11 nm take", take_o, 1);
        chk("R11 nm kind", take_nmi_o, 1);
        chk("R11 nm stall off", stall_o, 0);
        sync_busy_i = 1'b0;
        tick();

        // R11 maskable ends the stall
        set_flag();
        wait_op_i = 1'b1; sync_busy_i = 1'b1;
        boundary();
        wait_op_i = 1'b0;
        tick(2);
        mask_req_i = 1'b1; tick(); mask_req_i = 1'b0;
        chk("R11 m take", take_o, 1);
        chk("R11 m kind", take_nmi_o, 0);
        chk("R11 m stall off", stall_o, 0);
        chk("R11 m ack", ack_pulse_o, 1);
        sync_busy_i = 1'b0;
        tick(SEQ_LEN + 1);

        // random phase against a transaction model (R3 R5 R6 R2)
        m_ien = ien_o;
        m_pend = 1'b0;
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom % 3;
            if (op == 1) begin set_flag(); m_ien = 1'b1; end
            else if (op == 2) begin clr_flag(); m_ien = 1'b0; end
            if (($urandom % 4) == 0) begin nm_pulse(); m_pend = 1'b1; end
            r_req = 1'($urandom % 2);
            mask_req_i = r_req;
            boundary();
            mask_req_i = 1'b0;
            e_take = m_pend | (r_req & m_ien);
            chk("R3 random take", take_o, e_take);
            if (e_take) chk("R6 random kind", take_nmi_o, m_pend);
            if (e_take) begin m_ien = 1'b0; m_pend = 1'b0; end
            chk("R2 random flag", ien_o, m_ien);
            tick(SEQ_LEN + 1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule